// File: doc/BRIEF.md
# Integer ALU with Immediate Operands

This block is the combinational arithmetic and logic stage of a small load-store integer core. It receives a register operand, a second register operand or a 16-bit constant taken from the instruction word, and an operation code. In the same cycle it returns a 32-bit result and a flag that is high when that result is zero. The decode stage only has to say which operation it wants and whether the constant replaces the second register.

Widening of the constant happens inside the block. Add, subtract and set-less-than treat the constant as a signed value. AND, OR and XOR treat it as unsigned. The upper-immediate operation moves the constant into the top half of the word and clears the bottom half. After it, an OR with a constant fills the low half, so any 32-bit value can be built with two operations. Add and subtract wrap silently and raise no trap. Set-less-than returns the word 1 or the word 0.

Top module: `int_alu`

## Requirements
- R1: When `use_imm` is 0 the second operand is `b_i`. When `use_imm` is 1 it is the widened `imm_i`, and `b_i` has no effect on the result.
- R2: Operation code 0 (add) returns `a_i` plus the second operand, wrapped modulo 2^32.
- R3: Operation code 1 (subtract) returns `a_i` minus the second operand, wrapped modulo 2^32.
- R4: Operation code 2 (set-less-than) returns 32'd1 when `a_i` is below the second operand as a signed two's-complement number, and 32'd0 otherwise.
- R5: Operation codes 3, 4 and 5 return the bitwise AND, OR and XOR of `a_i` and the second operand.
- R6: For codes 0, 1 and 2 a constant is sign-extended: its bit 15 is copied into bits 31..16.
- R7: For codes 3, 4 and 5 a constant is zero-extended: bits 31..16 of the second operand are 0.
- R8: Operation code 6 (load upper) returns `imm_i` in bits 31..16 and 0 in bits 15..0. It ignores `a_i`, `b_i` and `use_imm`.
- R9: `zero_o` is 1 exactly when `result_o` equals 0.
- R10: The unused operation code 7 returns 0 whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 slt, 3 and, 4 or, 5 xor, 6 load upper, 7 unused |
| use_imm | input | 1 | Use the widened constant instead of `b_i` |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Instruction constant |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
Every operation code is tried with both operand sources. Each runs over a cross of corner words: zero, one, all ones, the most negative and most positive values, and half-word masks. These tell wrapping from saturation, signed compares from unsigned ones, and sign extension from zero extension, since each constant has bit 15 both set and clear. Pseudo-random operands then cover the general datapath. Random `b_i` values under `use_imm` show that the register operand is ignored. Load upper runs with random `a_i` and `b_i` to show that both are ignored.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SLT  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_LUI  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  // arithmetic helpers kept here so the datapath reads as calls
  function automatic logic [63:0] f_add(input logic [63:0] x, input logic [63:0] y);
    return x + y;
  endfunction

  function automatic logic [63:0] f_sub(input logic [63:0] x, input logic [63:0] y);
    return x - y;
  endfunction

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
  endfunction
endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] wide
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill;
  assign fill = sign_ext & imm[IMM_W-1];
  assign wide = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              lt_signed
);
  localparam int MSB = DATA_W - 1;

  logic [63:0] x64, y64, s64, d64;

  assign x64 = 64'(x);
  assign y64 = 64'(y);
  assign s64 = f_add(x64, y64);
  assign d64 = f_sub(x64, y64);

  assign sum  = s64[DATA_W-1:0];
  assign diff = d64[DATA_W-1:0];

  // differing signs decide directly; equal signs cannot overflow the difference
  assign lt_signed = (x[MSB] != y[MSB]) ? x[MSB] : diff[MSB];

  logic unused_hi;
  assign unused_hi = ^{s64[63:DATA_W], d64[63:DATA_W]};
endmodule

// File: rtl/logic_unit.sv
module logic_unit
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_XOR:  res = x ^ y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [2:0]        op_i,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // named internal events, observed by the bound checker
  logic              sext_sel;
  logic [DATA_W-1:0] imm_wide;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] add_res, sub_res, log_res;
  logic              lt_flag;
  logic [DATA_W-1:0] slt_word;
  logic [DATA_W-1:0] lui_word;

  assign sext_sel = is_arith(op);

  imm_widen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_widen (
    .imm      (imm_i),
    .sign_ext (sext_sel),
    .wide     (imm_wide)
  );

  assign opnd_b = use_imm ? imm_wide : b_i;

  arith_unit #(.DATA_W(DATA_W)) u_arith (
    .x         (a_i),
    .y         (opnd_b),
    .sum       (add_res),
    .diff      (sub_res),
    .lt_signed (lt_flag)
  );

  logic_unit #(.DATA_W(DATA_W)) u_logic (
    .op  (op),
    .x   (a_i),
    .y   (opnd_b),
    .res (log_res)
  );

  assign slt_word = {{(DATA_W-1){1'b0}}, lt_flag};
  assign lui_word = {imm_i, {LOW_W{1'b0}}};

  always_comb begin
    unique case (op)
      OP_ADD:                 result_o = add_res;
      OP_SUB:                 result_o = sub_res;
      OP_SLT:                 result_o = slt_word;
      OP_AND, OP_OR, OP_XOR:  result_o = log_res;
      OP_LUI:                 result_o = lui_word;
      default:                result_o = '0;
    endcase
  end

  assign zero_o = (result_o == '0);
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [2:0]        op_i,
  input logic              use_imm,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  logic known;
  assign known = !$isunknown({op_i, use_imm, b_i, imm_i});

  always_comb begin
    if (known) begin
      // R1: register path passes b unchanged
      a_r1_reg_path: assert (use_imm || opnd_b == b_i);
      // R6: arithmetic constants carry the sign bit upward
      a_r6_sign_ext: assert (!(use_imm && op_i <= 3'd2) ||
                             opnd_b[DATA_W-1:IMM_W] == {LOW_W{imm_i[IMM_W-1]}});
      // R7: logic constants have an all-zero upper half
      a_r7_zero_ext: assert (!(use_imm && op_i >= 3'd3 && op_i <= 3'd5) ||
                             opnd_b[DATA_W-1:IMM_W] == '0);
      // R4: compare result is a 0/1 word
      a_r4_slt_word: assert (op_i != 3'd2 || result_o[DATA_W-1:1] == '0);
      // R8: load upper places the constant and clears the low half
      a_r8_lui_place: assert (op_i != 3'd6 ||
                              result_o == {imm_i, {LOW_W{1'b0}}});
      // R10: unused code yields zero
      a_r10_rsvd_zero: assert (op_i != 3'd7 || result_o == '0);
      // R9: flag agrees with the result word
      a_r9_zero_flag: assert (zero_o == (result_o == '0));
    end
  end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_i     (op_i),
  .use_imm  (use_imm),
  .b_i      (b_i),
  .imm_i    (imm_i),
  .opnd_b   (opnd_b),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
  logic        clk = 1'b0;
  logic [2:0]  op_i = '0;
  logic        use_imm = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        zero_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1BADF00D;

  always #5 clk = ~clk;

  int_alu dut (
    .op_i(op_i), .use_imm(use_imm), .a_i(a_i), .b_i(b_i),
    .imm_i(imm_i), .result_o(result_o), .zero_o(zero_o)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic ui,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] k);
    logic [31:0] y;
    if (!ui) y = b;                                     // R1
    else if (op <= 3'd2) y = 32'($signed(k));           // R6
    else y = 32'(k);                                    // R7
    case (op)
      3'd0: return a + y;                               // R2
      3'd1: return a + ~y + 32'd1;                      // R3
      3'd2: return ($signed(a) < $signed(y)) ? 32'd1 : 32'd0; // R4
      3'd3: return a & y;                               // R5
      3'd4: return a | y;
      3'd5: return a ^ y;
      3'd6: return 32'(k) * 32'd65536;                  // R8
      default: return 32'd0;                            // R10
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op, input logic ui);
    string s;
    case (op)
      3'd0: s = "R2";  3'd1: s = "R3";  3'd2: s = "R4";
      3'd3, 3'd4, 3'd5: s = "R5";
      3'd6: s = "R8";  default: s = "R10";
    endcase
    if (ui && op <= 3'd2) s = {s, "/R6/R1"};
    else if (ui && op <= 3'd5) s = {s, "/R7/R1"};
    return s;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic run(input logic [2:0] op, input logic ui, input logic [31:0] a,
                     input logic [31:0] b, input logic [15:0] k);
    logic [31:0] exp;
    @(posedge clk);
    op_i = op; use_imm = ui; a_i = a; b_i = b; imm_i = k;
    exp = model(op, ui, a, b, k);
    @(negedge clk);
    checks++;
    if (result_o !== exp) begin
      errors++;
      $display("FAIL %s op=%0d imm=%0b a=%h b=%h k=%h: got %h expected %h",
               tag(op, ui), op, ui, a, b, k, result_o, exp);
    end
    checks++;
    if (zero_o !== (exp == 32'd0)) begin
      errors++;
      $display("FAIL R9 zero flag: got %b expected %b", zero_o, exp == 32'd0);
    end
  endtask

  logic [31:0] cw [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                          32'h7FFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 32'h12345678};
  logic [15:0] ck [8] = '{16'h0, 16'h1, 16'hFFFF, 16'h8000,
                          16'h7FFF, 16'h00FF, 16'hFF00, 16'h8001};

  initial begin
    // reset-state style check: all-zero inputs, add gives zero and raises the flag
    @(negedge clk);
    checks++;
    if (result_o !== 32'd0 || zero_o !== 1'b1) begin
      errors++;
      $display("FAIL R9 idle: got %h/%b expected 0/1", result_o, zero_o);
    end
    // corner cross over every code and both sources
    for (int op = 0; op < 8; op++)
      for (int ui = 0; ui < 2; ui++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run(3'(op), 1'(ui), cw[i], cw[j], ck[(i + j) % 8]);
    // wrap and sign corners called out directly
    run(3'd0, 1'b0, 32'hFFFFFFFF, 32'h1, 16'h0);          // R2 wraps to 0
    run(3'd1, 1'b0, 32'h0, 32'h1, 16'h0);                 // R3 wraps to all ones
    run(3'd2, 1'b0, 32'h80000000, 32'h7FFFFFFF, 16'h0);   // R4 signed: 1
    run(3'd2, 1'b1, 32'h0, 32'h0, 16'hFFFF);              // R6: 0 < -1 false
    run(3'd4, 1'b1, 32'h0, 32'h0, 16'hFFFF);              // R7 gives 0000FFFF
    run(3'd6, 1'b0, 32'hDEADBEEF, 32'hCAFEF00D, 16'hA5A5);// R8 ignores a,b
    // random sweep; random b under use_imm shows b is ignored
    for (int n = 0; n < 400; n++)
      for (int op = 0; op < 8; op++) begin
        logic [31:0] ra, rb;
        rng = nxt(rng); ra = rng;
        rng = nxt(rng); rb = rng;
        run(3'(op), rb[7], ra, rb, ra[23:8]);
      end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule